// File: doc/BRIEF.md
# Two-Channel Compare Waveform Generator

This block pairs a free-running up-counter with two compare channels, named A and B. Each channel owns a waveform state bit. The bit is set, cleared or toggled when the counter equals that channel's compare value, and in the PWM regime also when the counter reaches its TOP value. A 4-bit waveform selector picks how the counter counts and where TOP comes from:

- free running over the full range,
- clear-on-compare,
- fast PWM, with TOP taken from a fixed width, a dedicated TOP register, or the channel A compare value.

Each channel has a 2-bit action code. The same code means different things in the non-PWM and the fast PWM regimes. A channel with a live action drives its pin from the waveform bit instead of from ordinary port data. A pin carries a value only when its direction bit is set.

Software reaches the block through a simple register write port and a combinational read port.

Top module: `cwu_top`

## Requirements
- R1: Synchronous active-high reset clears all registers and the counter to zero, so every read returns 0.
- R2: Address map:
  - Address 0 is the control register: channel A code in bits 7:6, channel B code in bits 5:4, waveform selector bits 1:0 in bits 1:0. Its bits 3:2 always read 0.
  - Address 1 holds waveform selector bits 3:2 in its bits 1:0.
  - Addresses 2 and 3 hold the A and B compare values.
  - Address 4 holds the TOP register.
  - Address 5 reads the counter, and a write to it loads the counter.
- R3: In selector 0, and in any selector value not listed in R4 or R5, the counter increments every clock and wraps from 0xFFFF to 0. A counter load takes priority over counting.
- R4: In clear-on-compare mode the counter goes to 0 on the clock after it equals its TOP. Selector 4 takes TOP from compare A, and selector 12 takes it from the TOP register.
- R5: In fast PWM the counter goes to 0 on the clock after it equals TOP. Selectors 5, 6 and 7 use TOP = 0x00FF, 0x01FF and 0x03FF. Selector 14 takes TOP from the TOP register, and selector 15 takes it from compare A.
- R6: Outside fast PWM the action codes work as follows:
  - Code 01 toggles the waveform bit on a compare match.
  - Code 10 clears it on a match.
  - Code 11 sets it on a match.

  The bit changes on the clock edge after the one that left the counter at the matching value. With no match and no TOP event the bit holds.
- R7: In fast PWM:
  - Code 10 clears the bit on a match and sets it at TOP.
  - Code 11 sets the bit on a match and clears it at TOP.
- R8: In fast PWM, code 01 toggles channel A on a match only for selectors 14 and 15. Channel B with code 01 is always disconnected. For other PWM selectors, code 01 leaves both channels disconnected with their bits unchanged.
- R9: In fast PWM, when a channel with code 1x has a compare value equal to TOP, its match is ignored and only its TOP action is applied.
- R10: Pin bit 0 belongs to channel A and pin bit 1 to channel B. A connected channel drives its waveform bit and a disconnected one passes its port data bit. A pin whose direction bit is 0 outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | CNT_W (16) | Register write data |
| rd_addr | input | AW (3) | Register read address |
| rd_data | output | CNT_W (16) | Register read data (combinational) |
| dir | input | 2 | Per-pin direction (1 = drive) |
| port_data | input | 2 | Ordinary port output values |
| pin_o | output | 2 | Pin values, bit 0 channel A, bit 1 channel B |

## Verification
The hardest situation to reach from the ports is a fast PWM channel whose compare value equals TOP. Its match and its TOP event then fall on the same clock, and only the TOP action may take effect. The bench loads the counter directly through address 5 to pin the phase. It then samples exactly 21 clocks later, when the counter has just passed TOP = 20, for both the setting and the clearing code. Toggle checks first force a known waveform bit with a non-PWM set-on-match. This lets the following PWM toggles be predicted.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
  localparam int ADR_CTRL = 0;
  localparam int ADR_WGH  = 1;
  localparam int ADR_CMPA = 2;
  localparam int ADR_CMPB = 3;
  localparam int ADR_TOP  = 4;
  localparam int ADR_CNT  = 5;
  localparam int NCH      = 2;

  typedef enum logic [1:0] {CNT_FREE, CNT_CLEAR, CNT_PWM} cnt_kind_e;
  typedef enum logic [2:0] {TOP_MAX, TOP_CMPA, TOP_REG, TOP_8B, TOP_9B, TOP_10B} top_src_e;

  typedef struct packed {
    cnt_kind_e kind;
    top_src_e  src;
  } wave_cfg_t;

  function automatic wave_cfg_t decode_wave(input logic [3:0] sel);
    wave_cfg_t c;
    case (sel)
      4'd4:    c = '{kind: CNT_CLEAR, src: TOP_CMPA};
      4'd12:   c = '{kind: CNT_CLEAR, src: TOP_REG};
      4'd5:    c = '{kind: CNT_PWM,   src: TOP_8B};
      4'd6:    c = '{kind: CNT_PWM,   src: TOP_9B};
      4'd7:    c = '{kind: CNT_PWM,   src: TOP_10B};
      4'd14:   c = '{kind: CNT_PWM,   src: TOP_REG};
      4'd15:   c = '{kind: CNT_PWM,   src: TOP_CMPA};
      default: c = '{kind: CNT_FREE,  src: TOP_MAX};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cwu_regs.sv
module cwu_regs
  import cwu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [1:0]       code_a,
  output logic [1:0]       code_b,
  output logic [3:0]       wsel,
  output logic [CNT_W-1:0] cmp_a,
  output logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] top_reg,
  output logic             cnt_we,
  output logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_a  <= '0;
      code_b  <= '0;
      wsel    <= '0;
      cmp_a   <= '0;
      cmp_b   <= '0;
      top_reg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(ADR_CTRL): begin
          code_a    <= wr_data[7:6];
          code_b    <= wr_data[5:4];
          wsel[1:0] <= wr_data[1:0];
        end
        AW'(ADR_WGH):  wsel[3:2] <= wr_data[1:0];
        AW'(ADR_CMPA): cmp_a     <= wr_data;
        AW'(ADR_CMPB): cmp_b     <= wr_data;
        AW'(ADR_TOP):  top_reg   <= wr_data;
        default: ;
      endcase
    end
  end

  assign cnt_we    = wr_en && (wr_addr == AW'(ADR_CNT));
  assign cnt_wdata = wr_data;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(ADR_CTRL): rd_data[7:0] = {code_a, code_b, 2'b00, wsel[1:0]};
      AW'(ADR_WGH):  rd_data[1:0] = wsel[3:2];
      AW'(ADR_CMPA): rd_data      = cmp_a;
      AW'(ADR_CMPB): rd_data      = cmp_b;
      AW'(ADR_TOP):  rd_data      = top_reg;
      AW'(ADR_CNT):  rd_data      = cnt_val;
      default:       rd_data      = '0;
    endcase
  end

  // R2: compare writes land on the following edge
  p_cmpa_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(ADR_CMPA)) |=> (cmp_a == $past(wr_data)));
endmodule

// File: rtl/cwu_counter.sv
module cwu_counter
  import cwu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  wave_cfg_t        cfg,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] top_reg,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] top_val
);
  localparam logic [CNT_W-1:0] TOP_FULL = '1;
  localparam logic [CNT_W-1:0] TOP_W8   = CNT_W'(32'h00FF);
  localparam logic [CNT_W-1:0] TOP_W9   = CNT_W'(32'h01FF);
  localparam logic [CNT_W-1:0] TOP_W10  = CNT_W'(32'h03FF);

  logic wrap_now;

  always_comb begin
    case (cfg.src)
      TOP_CMPA: top_val = cmp_a;
      TOP_REG:  top_val = top_reg;
      TOP_8B:   top_val = TOP_W8;
      TOP_9B:   top_val = TOP_W9;
      TOP_10B:  top_val = TOP_W10;
      default:  top_val = TOP_FULL;
    endcase
  end

  assign wrap_now = (cfg.kind != CNT_FREE) && (cnt_q == top_val);

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (cnt_we)   cnt_q <= cnt_wdata;
    else if (wrap_now) cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3: a software load lands exactly
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));
  // R4 / R5: reaching TOP in a clearing regime restarts from zero
  p_top_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && cfg.kind != CNT_FREE && cnt_q == top_val) |=> (cnt_q == '0));
  // R3: otherwise the count advances by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && cfg.kind == CNT_FREE) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/cwu_channel.sv
module cwu_channel
  import cwu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit CHAN_A = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       code,
  input  logic [3:0]       wsel,
  input  cnt_kind_e        kind,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] top_val,
  output logic             wave_q,
  output logic             linked
);
  logic is_pwm, hit, at_top, tog_ok, wave_d;

  assign is_pwm = (kind == CNT_PWM);
  assign hit    = (cnt == cmp);
  assign at_top = is_pwm && (cnt == top_val);
  assign tog_ok = CHAN_A && (wsel == 4'd14 || wsel == 4'd15);

  always_comb begin
    wave_d = wave_q;
    linked = 1'b0;
    if (!is_pwm) begin
      linked = (code != 2'b00);
      if (hit) begin
        case (code)
          2'b01:   wave_d = ~wave_q;
          2'b10:   wave_d = 1'b0;
          2'b11:   wave_d = 1'b1;
          default: wave_d = wave_q;
        endcase
      end
    end else if (code[1]) begin
      linked = 1'b1;
      if (at_top) wave_d = ~code[0];
      if (hit && (cmp != top_val)) wave_d = code[0];
    end else if (code == 2'b01 && tog_ok) begin
      linked = 1'b1;
      if (hit) wave_d = ~wave_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else     wave_q <= wave_d;
  end

  // R6: without a match or TOP event the waveform bit holds
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!hit && !at_top) |=> $stable(wave_q));
  // R9: compare equal to TOP applies only the TOP action
  p_top_only_r9: assert property (@(posedge clk) disable iff (rst)
    (at_top && code[1] && cmp == top_val) |=> (wave_q != $past(code[0])));
  // R8: a disallowed toggle request leaves the bit untouched
  p_no_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && code == 2'b01 && !tog_ok) |=> $stable(wave_q));
endmodule

// File: rtl/cwu_top.sv
module cwu_top
  import cwu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic [NCH-1:0]   dir,
  input  logic [NCH-1:0]   port_data,
  output logic [NCH-1:0]   pin_o
);
  logic [1:0]       code_a, code_b;
  logic [3:0]       wsel;
  logic [CNT_W-1:0] cmp_a, cmp_b, top_reg, cnt_wdata, cnt_q, top_val;
  logic             cnt_we;
  wave_cfg_t        cfg;
  logic [1:0]       code_arr [NCH];
  logic [CNT_W-1:0] cmp_arr  [NCH];
  logic [NCH-1:0]   wave, linked;

  cwu_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_val(cnt_q), .code_a(code_a), .code_b(code_b),
    .wsel(wsel), .cmp_a(cmp_a), .cmp_b(cmp_b), .top_reg(top_reg),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rd_data(rd_data)
  );

  assign cfg = decode_wave(wsel);

  cwu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cfg(cfg), .cmp_a(cmp_a), .top_reg(top_reg),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .top_val(top_val)
  );

  assign code_arr[0] = code_a;
  assign code_arr[1] = code_b;
  assign cmp_arr[0]  = cmp_a;
  assign cmp_arr[1]  = cmp_b;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    cwu_channel #(.CNT_W(CNT_W), .CHAN_A(gi == 0)) u_ch (
      .clk(clk), .rst(rst), .code(code_arr[gi]), .wsel(wsel), .kind(cfg.kind),
      .cnt(cnt_q), .cmp(cmp_arr[gi]), .top_val(top_val),
      .wave_q(wave[gi]), .linked(linked[gi])
    );
    assign pin_o[gi] = dir[gi] & (linked[gi] ? wave[gi] : port_data[gi]);
  end

  // R10: an input-direction pin never carries a one
  p_pin_gate_r10: assert property (@(posedge clk) disable iff (rst)
    ((pin_o & ~dir) == '0));
endmodule

// File: tb/cwu_top_tb_top.sv
module cwu_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [15:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  dir = 2'b00;
  logic [1:0]  port_data = 2'b00;
  logic [1:0]  pin_o;

  item_t sb_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  cwu_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dir(dir), .port_data(port_data),
    .pin_o(pin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = sb_q.pop_front();
      act = it.is_rd ? rd_data : {14'b0, pin_o};
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic exp_pin(input string tag, input logic [1:0] v);
    sb_q.push_back('{tag: tag, is_rd: 1'b0, exp: {14'b0, v}});
  endtask

  task automatic exp_rd(input string tag, input logic [2:0] a, input logic [15:0] v);
    rd_addr = a;
    sb_q.push_back('{tag: tag, is_rd: 1'b1, exp: v});
  endtask

  task automatic drain();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    ticks(3);
    exp_rd("R1 ctrl after reset", 3'd0, 16'h0000); drain();
    exp_rd("R1 counter after reset", 3'd5, 16'h0000); drain();
    exp_pin("R1 pins after reset", 2'b00); drain();
    rst = 1'b0;

    dir = 2'b11; port_data = 2'b10; #1;
    exp_pin("R10 disconnected pins pass port data", 2'b10);

    // non-PWM set / clear / toggle
    wr(3'd2, 16'd100); wr(3'd3, 16'd100); wr(3'd0, 16'h00E0);
    wr(3'd5, 16'd100); tick();
    exp_pin("R6 set A clear B on match", 2'b01);
    wr(3'd0, 16'h00B0); wr(3'd5, 16'd100); tick();
    exp_pin("R6 clear A set B on match", 2'b10);
    wr(3'd0, 16'h0050); wr(3'd5, 16'd100); tick();
    exp_pin("R6 toggle both first", 2'b01);
    wr(3'd5, 16'd100); tick();
    exp_pin("R6 toggle both second", 2'b10);
    ticks(5);
    exp_pin("R6 hold without match", 2'b10);
    exp_rd("R3 counter advanced", 3'd5, 16'd106);

    // clear-on-compare
    wr(3'd2, 16'd10); wr(3'd1, 16'd1); wr(3'd5, 16'd8); ticks(3);
    exp_rd("R4 clear at compare A", 3'd5, 16'd0);
    exp_pin("R6 toggle A at CTC match", 2'b11);
    wr(3'd4, 16'd40); wr(3'd1, 16'd3); wr(3'd5, 16'd38); ticks(3);
    exp_rd("R4 clear at TOP register", 3'd5, 16'd0);

    // free-running wrap
    wr(3'd1, 16'd0); wr(3'd0, 16'h0000);
    exp_pin("R10 code 00 passes port data", 2'b10);
    wr(3'd5, 16'hFFFE); ticks(2);
    exp_rd("R3 wrap at full range", 3'd5, 16'd0);

    // register layout
    wr(3'd0, 16'hFFFF);
    exp_rd("R2 reserved control bits zero", 3'd0, 16'h00F3);
    wr(3'd1, 16'd3);
    exp_rd("R2 upper selector readback", 3'd1, 16'h0003);

    // fast PWM selector 15, B non-inverting then inverting
    wr(3'd2, 16'd20); wr(3'd3, 16'd5); wr(3'd0, 16'h0023); wr(3'd5, 16'd0);
    ticks(6);  exp_pin("R7 code 10 clear on match", 2'b00);
    ticks(15); exp_pin("R7 code 10 set at TOP", 2'b10);
    exp_rd("R5 restart after TOP = compare A", 3'd5, 16'd0);
    ticks(6);  exp_pin("R7 code 10 second period", 2'b00);
    wr(3'd0, 16'h0033); wr(3'd5, 16'd0);
    ticks(6);  exp_pin("R7 code 11 set on match", 2'b10);
    ticks(15); exp_pin("R7 code 11 clear at TOP", 2'b00);

    // compare equals TOP
    wr(3'd3, 16'd20); wr(3'd0, 16'h0023); wr(3'd5, 16'd0);
    ticks(21); exp_pin("R9 code 10 TOP set only", 2'b10);
    ticks(10); exp_pin("R9 code 10 stays set", 2'b10);
    wr(3'd0, 16'h0033); wr(3'd5, 16'd0);
    ticks(21); exp_pin("R9 code 11 TOP clear only", 2'b00);

    // fast PWM toggle on channel A
    wr(3'd1, 16'd0); wr(3'd2, 16'd20); wr(3'd0, 16'h00C0); wr(3'd5, 16'd20); tick();
    exp_pin("R6 preset A high", 2'b11);
    wr(3'd0, 16'h0053); wr(3'd1, 16'd3); wr(3'd5, 16'd0);
    ticks(21); exp_pin("R8 A toggles low, B disconnected", 2'b10);
    ticks(21); exp_pin("R8 A toggles high", 2'b11);
    wr(3'd1, 16'd1);
    exp_pin("R8 code 01 disconnected in selector 7", 2'b10);

    // fast PWM selector 14
    wr(3'd4, 16'd30); wr(3'd3, 16'd10); wr(3'd0, 16'h0022); wr(3'd1, 16'd3);
    wr(3'd5, 16'd0);
    ticks(11); exp_pin("R7 selector 14 clear on match", 2'b00);
    ticks(20); exp_pin("R5 selector 14 set at TOP register", 2'b10);
    exp_rd("R5 restart after TOP register", 3'd5, 16'd0);
    drain();

    // direction gating
    dir = 2'b01; #1;
    exp_pin("R10 B gated by direction", 2'b00);
    drain();
    dir = 2'b10; #1;
    exp_pin("R10 B driven with direction set", 2'b10);
    drain();

    done = 1'b1;
    finish_run();
  end
endmodule